// File: doc/BRIEF.md
# Multi-Port Transfer Performance Monitor

This block watches seven independent memory-controller ports and gathers traffic statistics for each one while profiling runs. Every port offers a small event interface: a request strobe with a direction bit and a 32-bit address, and a completion strobe that closes the transaction. For each port the monitor keeps three figures: how many transfers finished, the sum of their latencies and the worst latency seen. A global counter records how many cycles profiling has been running.

A port counts a transfer only if two filters pass. The first is a global type filter that keeps reads, writes or both. The second is the port's own address window, set in 8 KB steps. Software drives the block through one configuration word and one window word per port. Within the configuration word, one bit enables the monitor, another clears every counter, a third starts or stops collection, and a coded field picks the metric that each port's read-out word returns. Bandwidth and mean latency are then derived in software by dividing by the cycle count.

Top module: `perfmon_top`

## Requirements
- R1: After reset the monitor is enabled but not collecting. Every counter reads zero. Each port's window covers the whole region 0x2000_0000..0x2FFF_FFFF (low bound 0, high bound 0x7FFF).
- R2: A transfer's latency is the number of clock edges from the edge that accepts its request to the edge that samples its completion strobe, so the minimum is 1. A transfer is counted only if collection is active at the edge that samples its completion.
- R3: The type filter sits in configuration bits [9:8]. The value 1 keeps reads only (reqWrite=0), 2 keeps writes only (reqWrite=1), and 0 or 3 keeps both. The filter is applied when the request is accepted.
- R4: A request passes its port's window when all of these hold: address bits [31:28] equal 2, bits [27:13] are at least the low bound, and bits [27:13] are at most the high bound. In the window word, the low bound is in bits [14:0] and the high bound is in bits [30:16].
- R5: Each counted transfer raises the port's transfer count by one, adds its latency to the port's latency sum, and raises the port's maximum latency to that value if it is larger.
- R6: The cycle counter increases by one on every edge at which collection is active.
- R7: Configuration bit 0 enables the monitor and bit 4 starts collection, which runs only while both bits are set. When collection stops, every counter keeps its value.
- R8: A configuration write with bits [1:0] equal to 3 zeroes every counter, including the maximum latencies and the cycle count, at that same edge.
- R9: Every counter saturates at all ones instead of wrapping.
- R10: Configuration bits [13:11] choose the read-out: 1 gives the transfer count, 2 the latency sum, 3 the maximum latency, and 6 the cycle count, which is the same on every port. Any other value reads zero. Port p's word sits in metricOut[32p+31:32p].
- R11: Each port tracks one transfer at a time. A request that arrives while a transfer is outstanding is ignored, and so is a completion strobe that arrives while no transfer is outstanding.
- R12: Each port's counters respond only to that port's own traffic and window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration word write strobe |
| cfgWrData | input | 32 | Configuration word value |
| winWrEn | input | NPORT | Per-port window word write strobe |
| winWrData | input | 32 | Window word value (low [14:0], high [30:16]) |
| reqValid | input | NPORT | Per-port request strobe |
| reqWrite | input | NPORT | Per-port direction, 1 = write |
| reqAddr | input | NPORT*32 | Per-port request address, port p at [32p+31:32p] |
| doneStrobe | input | NPORT | Per-port completion strobe |
| metricOut | output | NPORT*32 | Per-port selected metric, zero-extended |

## Verification
The bench sweeps every type-filter setting, both directions on every port, and five address positions around each port's window. These positions are one step below the window, exactly on each bound, one step above it, and outside the region. A window test that is off by one, or that ignores the region nibble, shows up as a wrong transfer count. The bench drives a second request while a transfer is outstanding and a completion with no transfer outstanding. A design that re-arms on the second request, or counts the stray completion, reports the wrong count or latency. With a narrow counter build, the bench runs long transfers and then many short ones, so a wrapping counter reads a small value where the saturated maximum is expected. It also reads back after stop and after clear, which exposes counters that keep running or a maximum latency that survives a clear.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_CLR_BIT  = 1;
  localparam int CFG_RUN_BIT  = 4;
  localparam int CFG_TYPE_LSB = 8;
  localparam int CFG_SEL_LSB  = 11;

  localparam int WIN_W        = 15;
  localparam int FIELD_LSB    = 13;
  localparam int WIN_HIGH_LSB = 16;
  localparam logic [3:0] REGION_NIBBLE = 4'h2;

  typedef enum logic [1:0] {
    TYPE_BOTH  = 2'd0,
    TYPE_READ  = 2'd1,
    TYPE_WRITE = 2'd2,
    TYPE_BOTH2 = 2'd3
  } xfer_type_e;

  localparam logic [2:0] SEL_XFER   = 3'd1;
  localparam logic [2:0] SEL_LATSUM = 3'd2;
  localparam logic [2:0] SEL_LATMAX = 3'd3;
  localparam logic [2:0] SEL_CYCLES = 3'd6;

  typedef struct packed {
    logic       enable;
    logic       clear;
    logic       collect;
    xfer_type_e typeSel;
    logic [2:0] metricSel;
  } ctrl_strobe_t;

endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int NPORT = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [31:0]                  cfgWrData,
  input  logic [NPORT-1:0]             winWrEn,
  input  logic [31:0]                  winWrData,
  output ctrl_strobe_t                 strobes,
  output logic [NPORT-1:0][WIN_W-1:0]  winLow,
  output logic [NPORT-1:0][WIN_W-1:0]  winHigh
);

  logic       enReg;
  logic       runReg;
  logic [1:0] typeReg;
  logic [2:0] selReg;
  logic       unusedBits;

  assign unusedBits = ^{cfgWrData[31:14], cfgWrData[10], cfgWrData[7:5],
                        cfgWrData[3:2], winWrData[31], winWrData[15]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b1;
      runReg  <= 1'b0;
      typeReg <= 2'd0;
      selReg  <= 3'd0;
    end else if (cfgWrEn) begin
      enReg   <= cfgWrData[CFG_EN_BIT];
      runReg  <= cfgWrData[CFG_RUN_BIT];
      typeReg <= cfgWrData[CFG_TYPE_LSB +: 2];
      selReg  <= cfgWrData[CFG_SEL_LSB +: 3];
    end
  end

  always_comb begin
    strobes.enable    = enReg;
    strobes.clear     = cfgWrEn & cfgWrData[CFG_EN_BIT] & cfgWrData[CFG_CLR_BIT];
    strobes.collect   = enReg & runReg;
    strobes.typeSel   = xfer_type_e'(typeReg);
    strobes.metricSel = selReg;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winLow[p]  <= '0;
        winHigh[p] <= '1;
      end else if (winWrEn[p]) begin
        winLow[p]  <= winWrData[0 +: WIN_W];
        winHigh[p] <= winWrData[WIN_HIGH_LSB +: WIN_W];
      end
    end

    p_window_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      !winWrEn[p] |=> ($stable(winLow[p]) && $stable(winHigh[p])));
  end

  p_stop_on_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrData[CFG_RUN_BIT]) |=> !strobes.collect);

endmodule

// File: rtl/perfmon_port.sv
module perfmon_port
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic [WIN_W-1:0]   winLow,
  input  logic [WIN_W-1:0]   winHigh,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [31:0]        reqAddr,
  input  logic               doneStrobe,
  output logic [CNT_W-1:0]   xferCnt,
  output logic [CNT_W-1:0]   latSum,
  output logic [CNT_W-1:0]   latMax
);

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] satAdd(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  logic             busy;
  logic             hitReg;
  logic [CNT_W-1:0] latCnt;
  logic [WIN_W-1:0] addrField;
  logic             inRegion, inWindow, typeOk, reqHit;
  logic             accept, finish, countIt;
  logic [CNT_W-1:0] thisLat;
  logic             unusedBits;

  assign unusedBits = ^reqAddr[FIELD_LSB-1:0];

  always_comb begin
    addrField = reqAddr[FIELD_LSB +: WIN_W];
    inRegion  = (reqAddr[31:28] == REGION_NIBBLE);
    inWindow  = (addrField >= winLow) && (addrField <= winHigh);
    unique case (strobes.typeSel)
      TYPE_READ:  typeOk = !reqWrite;
      TYPE_WRITE: typeOk = reqWrite;
      default:    typeOk = 1'b1;
    endcase
    reqHit  = inRegion & inWindow & typeOk;
    accept  = reqValid & !busy & strobes.enable;
    finish  = doneStrobe & busy;
    countIt = finish & hitReg & strobes.collect;
    thisLat = satInc(latCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      hitReg <= 1'b0;
      latCnt <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      hitReg <= reqHit;
      latCnt <= '0;
    end else if (finish) begin
      busy   <= 1'b0;
    end else if (busy) begin
      latCnt <= satInc(latCnt);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferCnt <= '0;
      latSum  <= '0;
      latMax  <= '0;
    end else if (strobes.clear) begin
      xferCnt <= '0;
      latSum  <= '0;
      latMax  <= '0;
    end else if (countIt) begin
      xferCnt <= satInc(xferCnt);
      latSum  <= satAdd(latSum, thisLat);
      if (thisLat > latMax) latMax <= thisLat;
    end
  end

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (xferCnt == '0 && latSum == '0 && latMax == '0));

  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.collect && !strobes.clear) |=> ($stable(xferCnt) && $stable(latSum) && $stable(latMax)));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear |=> (xferCnt >= $past(xferCnt) && latSum >= $past(latSum)));

  p_max_within_sum_r5: assert property (@(posedge clk) disable iff (!rstN)
    latMax <= latSum);

  p_single_outstanding_r11: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && busy) |=> !busy);

endmodule

// File: rtl/perfmon_datapath.sv
module perfmon_datapath
  import perfmon_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobe_t                strobes,
  input  logic [NPORT-1:0][WIN_W-1:0] winLow,
  input  logic [NPORT-1:0][WIN_W-1:0] winHigh,
  input  logic [NPORT-1:0]            reqValid,
  input  logic [NPORT-1:0]            reqWrite,
  input  logic [NPORT*32-1:0]         reqAddr,
  input  logic [NPORT-1:0]            doneStrobe,
  output logic [NPORT*32-1:0]         metricOut
);

  localparam int RD_W = 32;

  logic [CNT_W-1:0] cycleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             cycleCnt <= '0;
    else if (strobes.clear)                cycleCnt <= '0;
    else if (strobes.collect && !(&cycleCnt)) cycleCnt <= cycleCnt + 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [CNT_W-1:0] xferCnt, latSum, latMax;
    logic [CNT_W-1:0] picked;

    perfmon_port #(.CNT_W(CNT_W)) u_port (
      .clk        (clk),
      .rstN       (rstN),
      .strobes    (strobes),
      .winLow     (winLow[p]),
      .winHigh    (winHigh[p]),
      .reqValid   (reqValid[p]),
      .reqWrite   (reqWrite[p]),
      .reqAddr    (reqAddr[p*RD_W +: RD_W]),
      .doneStrobe (doneStrobe[p]),
      .xferCnt    (xferCnt),
      .latSum     (latSum),
      .latMax     (latMax)
    );

    always_comb begin
      case (strobes.metricSel)
        SEL_XFER:   picked = xferCnt;
        SEL_LATSUM: picked = latSum;
        SEL_LATMAX: picked = latMax;
        SEL_CYCLES: picked = cycleCnt;
        default:    picked = '0;
      endcase
    end

    assign metricOut[p*RD_W +: RD_W] = RD_W'(picked);
  end

  p_cycle_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear |=> cycleCnt >= $past(cycleCnt));

  p_cycle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.collect && !strobes.clear) |=> $stable(cycleCnt));

  p_cycle_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> cycleCnt == '0);

endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
  import perfmon_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [31:0]         cfgWrData,
  input  logic [NPORT-1:0]    winWrEn,
  input  logic [31:0]         winWrData,
  input  logic [NPORT-1:0]    reqValid,
  input  logic [NPORT-1:0]    reqWrite,
  input  logic [NPORT*32-1:0] reqAddr,
  input  logic [NPORT-1:0]    doneStrobe,
  output logic [NPORT*32-1:0] metricOut
);

  ctrl_strobe_t                strobes;
  logic [NPORT-1:0][WIN_W-1:0] winLow;
  logic [NPORT-1:0][WIN_W-1:0] winHigh;

  perfmon_ctrl #(.NPORT(NPORT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .winWrEn   (winWrEn),
    .winWrData (winWrData),
    .strobes   (strobes),
    .winLow    (winLow),
    .winHigh   (winHigh)
  );

  perfmon_datapath #(.NPORT(NPORT), .CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .winLow     (winLow),
    .winHigh    (winHigh),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .doneStrobe (doneStrobe),
    .metricOut  (metricOut)
  );

endmodule

// File: tb/perfmon_top_bench.sv
module perfmon_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;
  localparam int CW = 8;
  localparam int SATV = 255;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgWrEn = 1'b0;
  logic [31:0]     cfgWrData = '0;
  logic [NP-1:0]   winWrEn = '0;
  logic [31:0]     winWrData = '0;
  logic [NP-1:0]   reqValid = '0;
  logic [NP-1:0]   reqWrite = '0;
  logic [NP*32-1:0] reqAddr = '0;
  logic [NP-1:0]   doneStrobe = '0;
  logic [NP*32-1:0] metricOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int expCnt[NP];
  int expSum[NP];
  int expMax[NP];

  perfmon_top #(.NPORT(NP), .CNT_W(CW)) u_perfmon_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .winWrEn(winWrEn), .winWrData(winWrData), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .doneStrobe(doneStrobe),
    .metricOut(metricOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sat(input int v);
    return (v > SATV) ? SATV : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // All tasks start and end at a falling edge.
  task automatic writeCfg(input logic [31:0] v, output int edgeIdx);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    edgeIdx = cyc;
  endtask

  task automatic writeWin(input int p, input int lo, input int hi);
    winWrEn[p] = 1'b1;
    winWrData = (32'(hi) << 16) | 32'(lo);
    @(negedge clk);
    winWrEn = '0;
  endtask

  task automatic doTxn(input int p, input bit w, input logic [31:0] a, input int lat);
    reqValid[p] = 1'b1; reqWrite[p] = w; reqAddr[p*32 +: 32] = a;
    @(negedge clk);
    reqValid[p] = 1'b0;
    repeat (lat - 1) @(negedge clk);
    doneStrobe[p] = 1'b1;
    @(negedge clk);
    doneStrobe[p] = 1'b0;
  endtask

  task automatic readPort(input int p, input int sel, input int typ,
                          input string req, input int exp);
    int e;
    writeCfg(32'h1 | (32'(typ) << 8) | (32'(sel) << 11), e);
    chk(req, int'(metricOut[p*32 +: 32]), exp);
  endtask

  function automatic logic [31:0] mkAddr(input int field, input int region, input int off);
    return (32'(region) << 28) | (32'(field) << 13) | 32'(off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int e, s, f;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values, every metric on every port
    for (int p = 0; p < NP; p++) begin
      readPort(p, 1, 0, "R1 reset count", 0);
      readPort(p, 2, 0, "R1 reset latsum", 0);
      readPort(p, 3, 0, "R1 reset latmax", 0);
      readPort(p, 6, 0, "R1 reset cycles", 0);
    end

    // R1 default windows cover the whole region
    writeCfg(32'h11, s);
    for (int p = 0; p < NP; p++) begin
      doTxn(p, 1'b0, 32'h2000_0000, 2);
      doTxn(p, 1'b1, 32'h2FFF_FFFC, 3);
    end
    writeCfg(32'h1, f);
    for (int p = 0; p < NP; p++) begin
      readPort(p, 1, 0, "R1 default window count", 2);
      readPort(p, 2, 0, "R1 R2 default window latsum", 5);
    end

    // Per-port windows: low=4+p, high=9+p
    for (int p = 0; p < NP; p++) writeWin(p, 4 + p, 9 + p);

    // Sweep over type filters, directions, addresses (R3 R4 R5 R6 R12)
    for (int typ = 0; typ < 4; typ++) begin
      writeCfg(32'h3, e);
      writeCfg(32'h11 | (32'(typ) << 8), s);
      for (int p = 0; p < NP; p++) begin
        expCnt[p] = 0; expSum[p] = 0; expMax[p] = 0;
        for (int w = 0; w < 2; w++) begin
          for (int k = 0; k < 5; k++) begin
            logic [31:0] a;
            int lat;
            bit typeOk, winOk;
            case (k)
              0: a = mkAddr(3 + p, 2, 0);
              1: a = mkAddr(4 + p, 2, 0);
              2: a = mkAddr(9 + p, 2, 13'h1FFF);
              3: a = mkAddr(10 + p, 2, 0);
              default: a = mkAddr(5 + p, 3, 0);
            endcase
            lat = 1 + ((p + k + w) % 4);
            doTxn(p, w[0], a, lat);
            typeOk = (typ == 1) ? (w == 0) : (typ == 2) ? (w == 1) : 1'b1;
            winOk = (k == 1 || k == 2);
            if (typeOk && winOk) begin
              expCnt[p]++;
              expSum[p] += lat;
              if (lat > expMax[p]) expMax[p] = lat;
            end
          end
        end
      end
      writeCfg(32'h1 | (32'(typ) << 8), f);
      for (int p = 0; p < NP; p++) begin
        readPort(p, 1, typ, "R3 R4 R12 count", sat(expCnt[p]));
        readPort(p, 2, typ, "R2 R5 latsum", sat(expSum[p]));
        readPort(p, 3, typ, "R5 latmax", expMax[p]);
        readPort(p, 6, typ, "R6 R10 cycles", sat(f - s));
      end
    end

    // R11 request while busy ignored, stray completion ignored
    writeCfg(32'h3, e);
    writeCfg(32'h11, s);
    reqValid[1] = 1'b1; reqWrite[1] = 1'b0; reqAddr[32 +: 32] = mkAddr(6, 2, 0);
    @(negedge clk);
    reqAddr[32 +: 32] = mkAddr(6, 3, 0);
    @(negedge clk);
    reqValid[1] = 1'b0;
    @(negedge clk);
    doneStrobe[1] = 1'b1;
    @(negedge clk);
    doneStrobe[1] = 1'b0;
    @(negedge clk);
    doneStrobe[1] = 1'b1;
    @(negedge clk);
    doneStrobe[1] = 1'b0;
    writeCfg(32'h1, f);
    readPort(1, 1, 0, "R11 count", 1);
    readPort(1, 2, 0, "R11 latency from first request", 3);

    // R7 stopped counters hold
    writeCfg(32'h3, e);
    writeCfg(32'h11, s);
    doTxn(2, 1'b1, mkAddr(8, 2, 0), 2);
    writeCfg(32'h1, f);
    doTxn(2, 1'b1, mkAddr(8, 2, 0), 4);
    repeat (5) @(negedge clk);
    readPort(2, 1, 0, "R7 count held", 1);
    readPort(2, 2, 0, "R7 latsum held", 2);
    readPort(2, 6, 0, "R7 cycles held", f - s);
    // R7 enable bit cleared stops collection even with start bit
    writeCfg(32'h10, e);
    doTxn(2, 1'b1, mkAddr(8, 2, 0), 2);
    readPort(2, 1, 0, "R7 disabled no count", 1);

    // R8 clear zeroes everything
    writeCfg(32'h3, e);
    for (int p = 0; p < NP; p++) begin
      readPort(p, 1, 0, "R8 cleared count", 0);
      readPort(p, 3, 0, "R8 cleared latmax", 0);
    end
    readPort(2, 2, 0, "R8 cleared latsum", 0);
    readPort(2, 6, 0, "R8 cleared cycles", 0);

    // R9 saturation
    writeCfg(32'h11, s);
    for (int i = 0; i < 5; i++) doTxn(0, 1'b0, mkAddr(6, 2, 0), 60);
    for (int i = 0; i < 260; i++) doTxn(3, 1'b1, mkAddr(9, 2, 0), 1);
    writeCfg(32'h1, f);
    readPort(0, 1, 0, "R9 count", 5);
    readPort(0, 2, 0, "R9 latsum saturates", SATV);
    readPort(0, 3, 0, "R9 latmax", 60);
    readPort(3, 1, 0, "R9 count saturates", SATV);
    readPort(3, 2, 0, "R9 latsum saturates short", SATV);
    readPort(5, 6, 0, "R9 cycles saturate", SATV);

    // R10 unused select values read zero
    readPort(0, 0, 0, "R10 sel0", 0);
    readPort(0, 4, 0, "R10 sel4", 0);
    readPort(3, 5, 0, "R10 sel5", 0);
    readPort(3, 7, 0, "R10 sel7", 0);

    summary();
  end
endmodule